// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs one set-vector-length operation per start pulse. It takes a requested application vector length, a requested type word and two flags that say whether the destination and the source register specifiers are zero. From these it works out the element width, the register grouping multiplier (whole or fractional) and the tail/mask policy bits. It then checks whether the configuration is legal and works out the maximum vector length for it. After that it picks a new vector length, updates the type and length registers, pulses a clear for the vector start index, and returns the granted length.

A caller raises `startIn` for one cycle with the operands stable. On the following cycle `doneOut` and `vstartClrOut` are high for one cycle, and `vlOut` and `vtypeOut` already hold the new values. An illegal request is recorded by writing a type word that has only its top bit set. The type is decoded again only when the requested word differs from the stored type. Otherwise the stored maximum length is reused.

Top module: `vl_config_unit`

## Requirements
- R1: After reset `vtypeOut` equals 1 << (XLEN-1), `vlOut` is 0, and `doneOut` and `vstartClrOut` are 0.
- R2: `doneOut` and `vstartClrOut` are high exactly in the cycle after a cycle with `startIn` high, and are low otherwise. The new `vlOut` and `vtypeOut` are visible in that same cycle.
- R3: Type bits [5:3] give the element width SEW = 8 << bits[5:3]. Type bits [2:0] are a two's-complement exponent k. For a legal type with k >= 0, vlmax = (VLEN/SEW) << k.
- R4: For a legal type with k in -1..-3, vlmax = (VLEN/SEW) >> -k. The fractional case is computed by shifting right.
- R5: A type is illegal if k = -4, or SEW > ELEN scaled by min(2^k,1), or any type bit at position 8 or above is set. In that case `vtypeOut` becomes 1 << (XLEN-1), vlmax is 0 and `vlOut` becomes 0.
- R6: With the source flag nonzero (`rs1ZeroIn`=0), the new vl is min(`avlIn`, vlmax).
- R7: With `rs1ZeroIn`=1 and `rdZeroIn`=0, the new vl is vlmax.
- R8: With both flags set, the new vl is the previous vl clamped to vlmax.
- R9: A legal type is stored into `vtypeOut` unchanged, including its tail-agnostic bit 6 and mask-agnostic bit 7. These two bits do not change the vl that is chosen.
- R10: Between operations `vtypeOut` and `vlOut` hold their values, and vl never exceeds the current vlmax.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request pulse |
| avlIn | input | XLEN | Requested application vector length |
| typeIn | input | XLEN | Requested type word |
| rdZeroIn | input | 1 | Destination specifier is zero |
| rs1ZeroIn | input | 1 | Source specifier is zero |
| doneOut | output | 1 | Result valid pulse |
| vstartClrOut | output | 1 | Vector start index clear strobe |
| vlOut | output | XLEN | Current (granted) vector length |
| vtypeOut | output | XLEN | Current type register |

## Verification
A wrong stored maximum length does not show up at once. It appears at the next operation that does not re-decode, where a both-zero or destination-only request then returns a vl that is off. The scoreboard carries a model of this stored maximum across operations, so such a fault is reported at the first later request that uses it. A wrong legality decision or a wrong shift shows up in `vlOut` or `vtypeOut` one cycle after the start pulse. A handshake that is stuck or late leaves a scoreboard entry unmatched, or raises done when nothing was started.

// File: rtl/vl_config_pkg.sv
package vl_config_pkg;
  typedef struct packed {
    logic commit;
    logic redecode;
  } vlStrobes_t;
endpackage

// File: rtl/vl_config_ctrl.sv
module vl_config_ctrl
  import vl_config_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       typeDiffers,
  output vlStrobes_t strobes,
  output logic       doneOut,
  output logic       vstartClrOut
);
  logic doneQ;

  always_comb begin
    strobes.commit   = startIn;
    strobes.redecode = startIn && typeDiffers;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= startIn;
  end

  assign doneOut      = doneQ;
  assign vstartClrOut = doneQ;

  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> doneOut);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !doneOut);
endmodule

// File: rtl/vl_config_datapath.sv
module vl_config_datapath
  import vl_config_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  vlStrobes_t      strobes,
  input  logic [XLEN-1:0] avlIn,
  input  logic [XLEN-1:0] typeIn,
  input  logic            rdZeroIn,
  input  logic            rs1ZeroIn,
  output logic            typeDiffers,
  output logic [XLEN-1:0] vlOut,
  output logic [XLEN-1:0] vtypeOut
);
  localparam int VLW = $clog2(VLEN) + 1;
  localparam logic [XLEN-1:0] ILL_TYPE = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] vtypeQ, vlQ, vtypeNext, vlNext;
  logic [VLW-1:0]  vlmaxQ, vlmaxNew, vlmaxEff;
  logic [XLEN-1:0] vlmaxWide;
  logic            newIllegal;

  logic signed [2:0] lmulExp;
  int sewLog, sewBits, perReg, scaled, sewLimit, lmulInt;
  logic badRange, badSew, badHigh;

  assign typeDiffers = (typeIn != vtypeQ);
  assign lmulExp     = typeIn[2:0];

  // field decode and legality
  always_comb begin
    lmulInt = int'(lmulExp);
    sewLog  = int'(typeIn[5:3]) + 3;
    sewBits = 1 << sewLog;
    perReg  = VLEN >> sewLog;
    if (lmulInt >= 0) begin
      scaled   = perReg << lmulInt;
      sewLimit = ELEN;
    end else begin
      scaled   = perReg >> (-lmulInt);
      sewLimit = ELEN >> (-lmulInt);
    end
    badRange   = (lmulInt == -4);
    badSew     = (sewBits > sewLimit);
    badHigh    = |typeIn[XLEN-1:8];
    newIllegal = badRange || badSew || badHigh;
    vlmaxNew   = newIllegal ? '0 : VLW'(scaled);
  end

  // length selection
  always_comb begin
    vlmaxEff  = strobes.redecode ? vlmaxNew : vlmaxQ;
    vtypeNext = strobes.redecode ? (newIllegal ? ILL_TYPE : typeIn) : vtypeQ;
    vlmaxWide = XLEN'(vlmaxEff);
    if (vlmaxEff == '0)
      vlNext = '0;
    else if (rdZeroIn && rs1ZeroIn)
      vlNext = (vlQ > vlmaxWide) ? vlmaxWide : vlQ;
    else if (rs1ZeroIn)
      vlNext = vlmaxWide;
    else
      vlNext = (avlIn > vlmaxWide) ? vlmaxWide : avlIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vtypeQ <= ILL_TYPE;
      vlQ    <= '0;
      vlmaxQ <= '0;
    end else if (strobes.commit) begin
      vtypeQ <= vtypeNext;
      vlQ    <= vlNext;
      vlmaxQ <= vlmaxEff;
    end
  end

  assign vlOut    = vlQ;
  assign vtypeOut = vtypeQ;

  // R10
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vlQ <= XLEN'(vlmaxQ));
  // R5
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtypeQ[XLEN-1] |-> (vlQ == '0));
  // R10
  hold_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(vtypeQ) && $stable(vlQ));
endmodule

// File: rtl/vl_config_unit.sv
module vl_config_unit
  import vl_config_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic [XLEN-1:0] avlIn,
  input  logic [XLEN-1:0] typeIn,
  input  logic            rdZeroIn,
  input  logic            rs1ZeroIn,
  output logic            doneOut,
  output logic            vstartClrOut,
  output logic [XLEN-1:0] vlOut,
  output logic [XLEN-1:0] vtypeOut
);
  vlStrobes_t strobes;
  logic       typeDiffers;

  vl_config_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .typeDiffers(typeDiffers),
    .strobes(strobes), .doneOut(doneOut), .vstartClrOut(vstartClrOut)
  );

  vl_config_datapath #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .avlIn(avlIn), .typeIn(typeIn),
    .rdZeroIn(rdZeroIn), .rs1ZeroIn(rs1ZeroIn), .typeDiffers(typeDiffers),
    .vlOut(vlOut), .vtypeOut(vtypeOut)
  );
endmodule

// File: tb/vl_config_unit_tb.sv
module vl_config_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int XLEN = 64;
  localparam logic [XLEN-1:0] ILL = {1'b1, {(XLEN-1){1'b0}}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [XLEN-1:0] avlIn = '0, typeIn = '0;
  logic rdZeroIn = 1'b0, rs1ZeroIn = 1'b0;
  logic doneOut, vstartClrOut;
  logic [XLEN-1:0] vlOut, vtypeOut;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [XLEN-1:0] expVlQ[$];
  logic [XLEN-1:0] expTypeQ[$];
  string           expTagQ[$];

  logic [XLEN-1:0] mVtype = ILL;
  logic [XLEN-1:0] mVl = '0;
  int              mVlmax = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_config_unit #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .avlIn(avlIn), .typeIn(typeIn),
    .rdZeroIn(rdZeroIn), .rs1ZeroIn(rs1ZeroIn), .doneOut(doneOut),
    .vstartClrOut(vstartClrOut), .vlOut(vlOut), .vtypeOut(vtypeOut)
  );

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // driver: model the requirements and push expectations
  task automatic doOp(logic [XLEN-1:0] avl, logic [XLEN-1:0] typ, bit rdZ, bit rs1Z, string tag);
    logic [XLEN-1:0] wl;
    if (typ != mVtype) begin
      int sewLog, k, perReg, lim, vm;
      bit ill;
      sewLog = int'(typ[5:3]) + 3;
      k = int'($signed(typ[2:0]));
      perReg = VLEN >> sewLog;
      if (k >= 0) begin vm = perReg << k; lim = ELEN; end
      else begin vm = perReg >> (-k); lim = ELEN >> (-k); end
      ill = (k == -4) || ((1 << sewLog) > lim) || (typ[XLEN-1:8] != 0);
      mVtype = ill ? ILL : typ;
      mVlmax = ill ? 0 : vm;
    end
    wl = XLEN'(mVlmax);
    if (mVlmax == 0) mVl = '0;
    else if (rdZ && rs1Z) mVl = (mVl > wl) ? wl : mVl;
    else if (rs1Z) mVl = wl;
    else mVl = (avl > wl) ? wl : avl;
    @(negedge clk);
    avlIn = avl; typeIn = typ; rdZeroIn = rdZ; rs1ZeroIn = rs1Z; startIn = 1'b1;
    expVlQ.push_back(mVl); expTypeQ.push_back(mVtype); expTagQ.push_back(tag);
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    check("R2 done drops", {63'd0, doneOut}, '0);
    check("R10 vl held", vlOut, mVl);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expVlQ.size() == 0) begin
        check("R2 unexpected done", 64'd1, 64'd0);
      end else begin
        string t;
        t = expTagQ.pop_front();
        check({t, " vl"}, vlOut, expVlQ.pop_front());
        check({t, " vtype"}, vtypeOut, expTypeQ.pop_front());
        check("R2 vstart clear", {63'd0, vstartClrOut}, 64'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 64'd1, 64'd0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vtype", vtypeOut, ILL);
    check("R1 vl", vlOut, '0);
    check("R1 done", {63'd0, doneOut}, '0);
    rstN = 1'b1;
    @(negedge clk);
    doOp(64'd5,   64'h00, 0, 0, "R6 avl below");
    doOp(64'd100, 64'h00, 0, 0, "R6 avl clamp");
    doOp(64'd0,   64'h13, 0, 1, "R3 R7 sew32 x8");
    doOp(64'd0,   64'h07, 1, 1, "R4 R8 half clamp");
    doOp(64'd7,   64'h05, 0, 0, "R4 eighth");
    doOp(64'd3,   64'h04, 0, 0, "R5 exp -4");
    doOp(64'd3,   64'h1F, 0, 0, "R5 sew over limit");
    doOp(64'd3,   64'h100, 0, 0, "R5 high bit");
    doOp(64'd3,   64'h38, 0, 0, "R5 sew1024");
    doOp(64'd9,   64'hC0, 0, 0, "R9 policy bits");
    doOp(64'd0,   64'hC0, 1, 1, "R8 same type keep");
    doOp(64'd0,   64'h18, 0, 1, "R3 R7 sew64 x1");
    doOp(64'd0,   64'h01, 0, 1, "R3 R7 sew8 x2");
    doOp(64'd0,   ILL,    0, 1, "R5 illegal repeat");
    repeat (3) @(negedge clk);
    check("R2 queue drained", 64'(expVlQ.size()), '0);
    summary();
  end
endmodule